// File: doc/BRIEF.md
# Write-Through Line-Fill Cache Sequencer

This block is the control engine that sits between a processor's memory port and a slow off-chip memory. The memory side uses one shared bus for address and data. The block watches the processor's access strobe and the hit flag from a direct-mapped store. It serves read hits at once. Every other access goes out over a request/ready/accept handshake.

Writes always go to memory first, so the store never holds a word that memory lacks. A write that hits also updates the cached word. A write that misses triggers a fill of the whole line, which is the write-allocate policy. A read miss also fetches the whole line, one word at a time, with a small counter supplying the word offset. The processor sees completion only after the line is fully in the store. Completion is a one-cycle pulse. The block then waits for the processor to drop its strobe before it accepts another access.

Top module: `wtCacheCtrl`

## Requirements
- R1: While `accStrobe` is low and the block is idle, `rdReq`, `wrReq`, `fillEn`, `wrEn`, `accDone` and `busDrive` stay low, whatever the other processor inputs do.
- R2: A read (`accWrite`=0) that finds `hitIn`=1 on the first cycle `accStrobe` is sampled completes with `accDone` high in the very next cycle. It raises no memory request.
- R3: A read miss raises `rdReq` and drives the line address on `busOut` (the access address with its low log2(`LINE_WORDS`) bits forced to 0, `busDrive`=1). It holds both until `memRdy` is seen.
- R4: Each fill word is taken in the cycle `memWordRdy` is high. In that cycle `fillEn` pulses and `rdAccept` rises. `rdAccept` is held until `memWordRdy` falls. The offsets on `fillOffset` run 0, 1, 2, 3 in that order, one per word.
- R5: `accDone` is raised only after the fourth fill word's handshake has closed, never while a fill is partly done.
- R6: Every write raises `wrReq` with the full access address on `busOut` until `memWrAck` rises. It then drops `wrReq` and drives `accWrData` on `busOut` until `memWrAck` falls.
- R7: A write whose `hitIn` was 1 at the start pulses `wrEn` for exactly one cycle once `memWrAck` has fallen, then completes, without any read request.
- R8: A write whose `hitIn` was 0 at the start does not pulse `wrEn`. After its write handshake it performs one full line fill as in R3 to R4, then completes.
- R9: `accDone` is high for one cycle only. After it, no request, fill, update or new completion occurs until `accStrobe` has gone low.
- R10: While `rst` is high and in the first cycle after it, every request, accept, enable and completion output is low and `fillOffset` is 0.
- R11: `rdReq` and `wrReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accStrobe | input | 1 | Processor memory-access strobe |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accAddr | input | BUS_W | Processor word address |
| accWrData | input | BUS_W | Processor write data |
| hitIn | input | 1 | Hit flag from the direct-mapped store for `accAddr` |
| accDone | output | 1 | One-cycle completion pulse to the processor |
| memRdy | input | 1 | Memory has taken the read request |
| memWordRdy | input | 1 | Memory presents a fill word |
| memWrAck | input | 1 | Memory write accept |
| rdReq | output | 1 | Read request to memory |
| rdAccept | output | 1 | Fill word accept to memory |
| wrReq | output | 1 | Write request to memory |
| busOut | output | BUS_W | Value driven onto the shared address/data bus |
| busDrive | output | 1 | Bus output enable |
| fillEn | output | 1 | Store write enable for the current fill word |
| wrEn | output | 1 | Store write enable for a write-hit word update |
| fillOffset | output | log2(LINE_WORDS) | Word offset of the current fill word |

## Verification
The bench builds the block with its defaults, a 16-bit bus and four-word lines. With these values the 2-bit offset counter wraps through every value on each fill, and it must restart at 0 on the next fill. Random 16-bit addresses land on all four word positions, so the masking of the two low bits in the line address is checked against addresses that have those bits set. A memory model with random response delays stretches every handshake phase. This shows that the requests and accepts are held for as long as the model waits.

// File: rtl/wtCachePkg.sv
package wtCachePkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDREQ,
    S_FILLWAIT,
    S_FILLACK,
    S_FILLLAST,
    S_WRADDR,
    S_WRDATA,
    S_DONE,
    S_HOLD
  } ctrlState_e;

  typedef enum logic [1:0] {
    BUS_OFF,
    BUS_LINE,
    BUS_WORD,
    BUS_DATA
  } busSel_e;

  // control -> datapath
  typedef struct packed {
    logic    capture;
    logic    clrCount;
    logic    stepCount;
    busSel_e busSel;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hitHeld;
    logic lastWord;
  } dpStatus_t;

endpackage

// File: rtl/wtCtrlDatapath.sv
module wtCtrlDatapath
  import wtCachePkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int LINE_WORDS = 4,
  parameter int OFF_W      = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strb,
  input  logic [BUS_W-1:0] accAddr,
  input  logic [BUS_W-1:0] accWrData,
  input  logic             hitIn,
  output dpStatus_t        status,
  output logic [OFF_W-1:0] fillOffset,
  output logic [BUS_W-1:0] busOut,
  output logic             busDrive
);

  localparam logic [BUS_W-1:0] LINE_MASK = ~(BUS_W'(LINE_WORDS - 1));
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(LINE_WORDS - 1);

  logic [BUS_W-1:0] addrHeld;
  logic [BUS_W-1:0] dataHeld;
  logic             hitHeld;
  logic [OFF_W-1:0] wordCnt;

  // access capture
  always_ff @(posedge clk) begin
    if (rst) begin
      addrHeld <= '0;
      dataHeld <= '0;
      hitHeld  <= 1'b0;
    end else if (strb.capture) begin
      addrHeld <= accAddr;
      dataHeld <= accWrData;
      hitHeld  <= hitIn;
    end
  end

  // fill offset counter
  always_ff @(posedge clk) begin
    if (rst || strb.clrCount) begin
      wordCnt <= '0;
    end else if (strb.stepCount) begin
      wordCnt <= wordCnt + 1'b1;
    end
  end

  // shared bus mux
  always_comb begin
    unique case (strb.busSel)
      BUS_LINE: busOut = addrHeld & LINE_MASK;
      BUS_WORD: busOut = addrHeld;
      BUS_DATA: busOut = dataHeld;
      default:  busOut = '0;
    endcase
  end

  assign busDrive        = (strb.busSel != BUS_OFF);
  assign fillOffset      = wordCnt;
  assign status.hitHeld  = hitHeld;
  assign status.lastWord = (wordCnt == LAST_OFF);

endmodule

// File: rtl/wtCtrlFsm.sv
module wtCtrlFsm
  import wtCachePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accStrobe,
  input  logic        accWrite,
  input  logic        hitIn,
  input  logic        memRdy,
  input  logic        memWordRdy,
  input  logic        memWrAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t strb,
  output logic        rdReq,
  output logic        rdAccept,
  output logic        wrReq,
  output logic        fillEn,
  output logic        wrEn,
  output logic        accDone
);

  ctrlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState      = state;
    strb.capture   = 1'b0;
    strb.clrCount  = 1'b0;
    strb.stepCount = 1'b0;
    strb.busSel    = BUS_OFF;
    rdReq          = 1'b0;
    rdAccept       = 1'b0;
    wrReq          = 1'b0;
    fillEn         = 1'b0;
    wrEn           = 1'b0;
    accDone        = 1'b0;

    unique case (state)
      S_IDLE: begin
        if (accStrobe) begin
          strb.capture = 1'b1;
          if (accWrite)   nextState = S_WRADDR;
          else if (hitIn) nextState = S_DONE;
          else            nextState = S_RDREQ;
        end
      end
      S_RDREQ: begin
        rdReq         = 1'b1;
        strb.busSel   = BUS_LINE;
        strb.clrCount = 1'b1;
        if (memRdy) nextState = S_FILLWAIT;
      end
      S_FILLWAIT: begin
        if (memWordRdy) begin
          fillEn         = 1'b1;
          rdAccept       = 1'b1;
          strb.stepCount = 1'b1;
          nextState      = status.lastWord ? S_FILLLAST : S_FILLACK;
        end
      end
      S_FILLACK: begin
        rdAccept = 1'b1;
        if (!memWordRdy) nextState = S_FILLWAIT;
      end
      S_FILLLAST: begin
        rdAccept = 1'b1;
        if (!memWordRdy) nextState = S_DONE;
      end
      S_WRADDR: begin
        wrReq       = 1'b1;
        strb.busSel = BUS_WORD;
        if (memWrAck) nextState = S_WRDATA;
      end
      S_WRDATA: begin
        strb.busSel = BUS_DATA;
        if (!memWrAck) begin
          if (status.hitHeld) begin
            wrEn      = 1'b1;
            nextState = S_DONE;
          end else begin
            nextState = S_RDREQ;
          end
        end
      end
      S_DONE: begin
        accDone   = 1'b1;
        nextState = S_HOLD;
      end
      S_HOLD: begin
        if (!accStrobe) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/wtCacheCtrl.sv
module wtCacheCtrl
  import wtCachePkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accStrobe,
  input  logic             accWrite,
  input  logic [BUS_W-1:0] accAddr,
  input  logic [BUS_W-1:0] accWrData,
  input  logic             hitIn,
  output logic             accDone,
  input  logic             memRdy,
  input  logic             memWordRdy,
  input  logic             memWrAck,
  output logic             rdReq,
  output logic             rdAccept,
  output logic             wrReq,
  output logic [BUS_W-1:0] busOut,
  output logic             busDrive,
  output logic             fillEn,
  output logic             wrEn,
  output logic [OFF_W-1:0] fillOffset
);

  ctrlStrobe_t ctrlStrb;
  dpStatus_t   dpStat;

  wtCtrlFsm uFsm (
    .clk        (clk),
    .rst        (rst),
    .accStrobe  (accStrobe),
    .accWrite   (accWrite),
    .hitIn      (hitIn),
    .memRdy     (memRdy),
    .memWordRdy (memWordRdy),
    .memWrAck   (memWrAck),
    .status     (dpStat),
    .strb       (ctrlStrb),
    .rdReq      (rdReq),
    .rdAccept   (rdAccept),
    .wrReq      (wrReq),
    .fillEn     (fillEn),
    .wrEn       (wrEn),
    .accDone    (accDone)
  );

  wtCtrlDatapath #(
    .BUS_W      (BUS_W),
    .LINE_WORDS (LINE_WORDS),
    .OFF_W      (OFF_W)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .strb       (ctrlStrb),
    .accAddr    (accAddr),
    .accWrData  (accWrData),
    .hitIn      (hitIn),
    .status     (dpStat),
    .fillOffset (fillOffset),
    .busOut     (busOut),
    .busDrive   (busDrive)
  );

endmodule

// File: rtl/wtCacheCtrlChecker.sv
module wtCacheCtrlChecker #(
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             accDone,
  input logic             memWordRdy,
  input logic             memWrAck,
  input logic             rdReq,
  input logic             rdAccept,
  input logic             wrReq,
  input logic             busDrive,
  input logic             fillEn,
  input logic             wrEn,
  input logic [OFF_W-1:0] fillOffset
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    accDone |=> !accDone); // R9

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rdReq && wrReq)); // R11

  AST_FILL_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    fillEn |-> (memWordRdy && rdAccept)); // R4

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
    fillEn |=> (fillOffset == OFF_W'($past(fillOffset) + 1'b1))); // R4

  AST_REQ_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    (rdReq || wrReq) |-> busDrive); // R3

  AST_UPDATE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (!memWrAck && !rdReq)); // R7

  AST_DONE_NOT_FILLING: assert property (@(posedge clk) disable iff (rst)
    accDone |-> (!rdAccept && !fillEn && !rdReq)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(rdReq || wrReq || rdAccept || fillEn || wrEn || accDone)); // R10

endmodule

bind wtCacheCtrl wtCacheCtrlChecker #(.LINE_WORDS(LINE_WORDS)) uChk (
  .clk        (clk),
  .rst        (rst),
  .accDone    (accDone),
  .memWordRdy (memWordRdy),
  .memWrAck   (memWrAck),
  .rdReq      (rdReq),
  .rdAccept   (rdAccept),
  .wrReq      (wrReq),
  .busDrive   (busDrive),
  .fillEn     (fillEn),
  .wrEn       (wrEn),
  .fillOffset (fillOffset)
);

// File: tb/sim_wtCacheCtrl.sv
module sim_wtCacheCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 16;
  localparam int LINE_WORDS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accStrobe = 1'b0, accWrite = 1'b0, hitIn = 1'b0;
  logic [BUS_W-1:0] accAddr = '0, accWrData = '0;
  logic memRdy = 1'b0, memWordRdy = 1'b0, memWrAck = 1'b0;
  logic accDone, rdReq, rdAccept, wrReq, busDrive, fillEn, wrEn;
  logic [BUS_W-1:0] busOut;
  logic [1:0] fillOffset;

  int checks = 0;
  int errors = 0;

  // transaction log filled by memory model and monitor
  int rdReqCnt, wrReqCnt, fillCnt, wrEnCnt, firstOp;
  logic [BUS_W-1:0] rdAddrLog, wrAddrLog, wrDataLog;
  logic wrDataDrv;
  logic [1:0] fillSeq [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  wtCacheCtrl #(.BUS_W(BUS_W), .LINE_WORDS(LINE_WORDS)) u0 (
    .clk(clk), .rst(rst), .accStrobe(accStrobe), .accWrite(accWrite),
    .accAddr(accAddr), .accWrData(accWrData), .hitIn(hitIn), .accDone(accDone),
    .memRdy(memRdy), .memWordRdy(memWordRdy), .memWrAck(memWrAck),
    .rdReq(rdReq), .rdAccept(rdAccept), .wrReq(wrReq), .busOut(busOut),
    .busDrive(busDrive), .fillEn(fillEn), .wrEn(wrEn), .fillOffset(fillOffset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] lineOf(input logic [BUS_W-1:0] a);
    return a & ~(BUS_W'(LINE_WORDS - 1));
  endfunction

  function automatic bit quietOut();
    return !(rdReq || wrReq || fillEn || wrEn || accDone || busDrive);
  endfunction

  // ---------------- memory model ----------------
  task automatic memRead();
    rdReqCnt++;
    if (firstOp == 0) firstOp = 2;
    rdAddrLog = busOut;
    chk(busDrive, "R3 bus driven with read request", int'(busDrive), 1);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(rdReq && busOut == rdAddrLog, "R3 request held until ready", int'(rdReq), 1);
    end
    memRdy = 1'b1;
    do @(negedge clk); while (rdReq);
    memRdy = 1'b0;
    for (int w = 0; w < LINE_WORDS; w++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      memWordRdy = 1'b1;
      do @(negedge clk); while (!rdAccept);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(rdAccept, "R4 accept held while word ready", int'(rdAccept), 1);
      end
      memWordRdy = 1'b0;
      do @(negedge clk); while (rdAccept);
    end
  endtask

  task automatic memWrite();
    wrReqCnt++;
    if (firstOp == 0) firstOp = 1;
    wrAddrLog = busOut;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(wrReq && busOut == wrAddrLog, "R6 write request held until accept", int'(wrReq), 1);
    end
    memWrAck = 1'b1;
    do @(negedge clk); while (wrReq);
    wrDataLog = busOut;
    wrDataDrv = busDrive;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    memWrAck = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rdReq)      memRead();
        else if (wrReq) memWrite();
      end
    end
  end

  // ---------------- monitor (quarter period after negedge) ----------------
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (!rst) begin
      if (fillEn) begin
        if (!(rdAccept && memWordRdy)) chk(1'b0, "R4 accept with fill word", int'(rdAccept), 1);
        if (fillCnt < 4) fillSeq[fillCnt] = fillOffset;
        fillCnt++;
      end
      if (wrEn) wrEnCnt++;
      if (accDone && fillCnt != 0 && fillCnt != 4) chk(1'b0, "R5 completion mid-fill", fillCnt, 4);
      if (rdReq && wrReq) chk(1'b0, "R11 requests exclusive", 1, 0);
    end
  end

  // ---------------- processor side ----------------
  task automatic checkFill(input string req);
    chk(fillCnt == 4, {req, " four fill words before completion"}, fillCnt, 4);
    for (int k = 0; k < 4; k++)
      chk(fillSeq[k] == 2'(k), {req, " fill offset order"}, int'(fillSeq[k]), k);
  endtask

  task automatic doAccess(input bit wr, input logic [BUS_W-1:0] a,
                          input logic [BUS_W-1:0] d, input bit hit);
    int cyc;
    @(negedge clk);
    rdReqCnt = 0; wrReqCnt = 0; fillCnt = 0; wrEnCnt = 0; firstOp = 0;
    accStrobe = 1'b1; accWrite = wr; accAddr = a; accWrData = d; hitIn = hit;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!accDone && cyc < 3000);
    chk(accDone, "R9 access completes", int'(accDone), 1);
    if (!wr && hit) begin
      chk(cyc == 1, "R2 read hit latency", cyc, 1);
      chk(rdReqCnt == 0 && wrReqCnt == 0 && fillCnt == 0, "R2 no memory traffic", rdReqCnt + wrReqCnt, 0);
    end else if (!wr) begin
      chk(rdReqCnt == 1 && wrReqCnt == 0, "R3 one read request", rdReqCnt, 1);
      chk(rdAddrLog == lineOf(a), "R3 line address on bus", int'(rdAddrLog), int'(lineOf(a)));
      checkFill("R5");
      chk(wrEnCnt == 0, "R4 no word update on read", wrEnCnt, 0);
    end else begin
      chk(wrReqCnt == 1, "R6 one write request", wrReqCnt, 1);
      chk(wrAddrLog == a, "R6 write address on bus", int'(wrAddrLog), int'(a));
      chk(wrDataLog == d && wrDataDrv, "R6 write data on bus", int'(wrDataLog), int'(d));
      if (hit) begin
        chk(wrEnCnt == 1, "R7 single word update", wrEnCnt, 1);
        chk(rdReqCnt == 0 && fillCnt == 0, "R7 no fill on write hit", rdReqCnt, 0);
      end else begin
        chk(wrEnCnt == 0, "R8 no word update on write miss", wrEnCnt, 0);
        chk(rdReqCnt == 1 && firstOp == 1, "R8 write then fill", firstOp, 1);
        chk(rdAddrLog == lineOf(a), "R8 fill line address", int'(rdAddrLog), int'(lineOf(a)));
        checkFill("R8");
      end
    end
    @(negedge clk);
    chk(!accDone, "R9 completion is one cycle", int'(accDone), 0);
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      chk(quietOut(), "R9 waits for strobe drop", int'(!quietOut()), 0);
    end
    accStrobe = 1'b0;
  endtask

  task automatic idleWindow(input int n);
    repeat (n) begin
      @(negedge clk);
      chk(quietOut(), "R1 idle with strobe low", int'(!quietOut()), 0);
      accStrobe = 1'b0;
      accWrite  = 1'($urandom);
      hitIn     = 1'($urandom);
      accAddr   = BUS_W'($urandom);
      accWrData = BUS_W'($urandom);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    accStrobe = 1'b1;
    repeat (3) @(negedge clk);
    chk(quietOut() && !rdAccept && fillOffset == 2'd0, "R10 outputs quiet in reset", int'(fillOffset), 0);
    accStrobe = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(quietOut() && !rdAccept && fillOffset == 2'd0, "R10 outputs quiet after reset", int'(!quietOut()), 0);

    idleWindow(12);

    // directed corners
    doAccess(1'b0, 16'h3005, 16'h0000, 1'b0); idleWindow(2); // read miss, mid-line
    doAccess(1'b0, 16'h3006, 16'h0000, 1'b1); idleWindow(2); // read hit
    doAccess(1'b1, 16'h3007, 16'h0023, 1'b1); idleWindow(2); // write hit
    doAccess(1'b1, 16'h3009, 16'hBEEF, 1'b0); idleWindow(2); // write miss + fill
    doAccess(1'b0, 16'hFFFF, 16'h0000, 1'b0); idleWindow(1); // last word of top line
    doAccess(1'b0, 16'h0000, 16'h0000, 1'b0); idleWindow(1); // first word, counter restarts

    // constrained random
    for (int i = 0; i < 60; i++) begin
      doAccess(1'($urandom), BUS_W'($urandom), BUS_W'($urandom), 1'($urandom));
      idleWindow(1 + $urandom_range(0, 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule